// File: doc/BRIEF.md
# UART Receive Status Byte Packer

This block sits between a UART character receiver and a byte-wide receive FIFO. Each time the receiver presents a finished character, the block turns it into bytes for the FIFO. The receiver supplies the character bits (5 to 9 of them), its per-character error flags and a one-cycle strobe. The FIFO side is a valid/ready write port, and a count of free FIFO entries is also supplied. Bit sampling, baud timing and the FIFO storage are outside this block.

The block has two formats. In the plain format each character becomes a single data byte and all error information is thrown away. In the extended format each character becomes a data byte followed by a status byte that carries the overrun, framing and break flags, plus either the parity flag or, for 9-bit characters, the ninth data bit. A character is taken only when the FIFO has room for every byte it will produce and no earlier character is still waiting to be written. Otherwise it is dropped, and the loss is reported as an overrun in the next status byte.

Back-pressure rules: a byte is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The two bytes of one character are always offered back to back, and no other character's byte can come between them.

Top module: `rx_status_packer`

## Requirements
- R1: With `cfg_wide`=0, every accepted character produces exactly one transfer on the output port, and the parity, framing, break and overrun inputs have no effect on it.
- R2: `cfg_bits` encodes the character width as 0=5, 1=6, 2=7, 3=8 and 4=9 bits (codes 5 to 7 act as 8). For 5, 6 or 7 bits, data byte bits at or above the width are 0.
- R3: With 9 bits in the plain format, the data byte is `chr_data[7:0]` and `chr_data[8]` is dropped.
- R4: With `cfg_wide`=1, a character produces two transfers: the data byte first, then the status byte. No other character's byte comes between them.
- R5: For 5 to 8 bits, the status byte is bit 3 overrun, bit 2 framing error, bit 1 break, bit 0 parity error, and bits 7:4 are 0.
- R6: Status bit 0 is 0 whenever `cfg_parity_en` is 0, for widths of 5 to 8 bits.
- R7: With 9 bits in the extended format, status bit 0 is `chr_data[8]`, the parity inputs are ignored, and bits 3:1 keep the overrun, framing and break positions.
- R8: A character is accepted only when no earlier bytes are pending and `fifo_room` is at least the number of bytes it needs (1 or 2). Otherwise it produces no transfer.
- R9: A dropped character sets a sticky overrun flag. This flag is ORed into bit 3 of the next accepted character's status byte and is cleared when that character is accepted.
- R10: Format and width are sampled on the `chr_valid` cycle. Later changes to them do not alter bytes that are already pending.
- R11: Synchronous active-high `rst` clears the pending bytes and the sticky overrun flag. `out_valid` is 0 in the cycle after reset.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bits | input | 3 | Character width code (0..4 = 5..9 bits) |
| cfg_parity_en | input | 1 | Parity checking enabled |
| cfg_wide | input | 1 | 1 = data byte plus status byte per character |
| chr_valid | input | 1 | One-cycle strobe for a received character |
| chr_data | input | 9 | Received character bits, LSB first received |
| chr_parity_err | input | 1 | Parity error for the character |
| chr_frame_err | input | 1 | Framing error for the character |
| chr_break | input | 1 | Break condition for the character |
| chr_overrun | input | 1 | Receiver overrun for the character |
| out_ready | input | 1 | FIFO accepts a byte this cycle |
| fifo_room | input | 6 | Free FIFO entries |
| out_valid | output | 1 | Byte offered to the FIFO |
| out_data | output | 8 | Byte offered to the FIFO |

## Verification
If the sequencer state is wrong, the ports show either a missing status byte, an extra byte, or a status byte with its upper nibble set. Any of these appears within two transfers of the character strobe. If the sticky overrun flag is wrong, bit 3 of the very next status byte is wrong, or a later status byte still shows bit 3 set. If the admission check is wrong, a character is written even though the FIFO lacked room for it, and this shows in the transfer count right after that strobe. A hold-register fault under back-pressure shows as `out_data` changing while `out_ready` is low.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int CHAR_W = 9;
  localparam int BYTE_W = CHAR_W - 1;

  typedef enum logic [1:0] {PK_IDLE, PK_DATA, PK_STAT} pk_state_e;

  localparam logic [2:0] WCODE_NINE = 3'd4;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic [BYTE_W-1:0] stat;
    logic              wide;
  } pk_pair_t;
endpackage

// File: rtl/rxp_format.sv
module rxp_format
  import rxp_pkg::*;
(
  input  logic [CHAR_W-1:0] char_in,
  input  logic [2:0]        bits,
  input  logic              par_en,
  input  logic              wide,
  input  logic              pe,
  input  logic              fe,
  input  logic              brk,
  input  logic              ovr,
  output pk_pair_t          pair
);
  logic              nine;
  logic [3:0]        lim;
  logic [BYTE_W-1:0] mask;

  always_comb begin
    nine = (bits == WCODE_NINE);
    lim  = (bits <= 3'd2) ? (4'd5 + {1'b0, bits}) : 4'd8;
    for (int j = 0; j < BYTE_W; j++) begin
      mask[j] = (j < int'(lim));
    end
    pair.data    = char_in[BYTE_W-1:0] & mask;
    pair.stat    = '0;
    pair.stat[3] = ovr;
    pair.stat[2] = fe;
    pair.stat[1] = brk;
    pair.stat[0] = nine ? char_in[CHAR_W-1] : (pe & par_en);
    pair.wide    = wide;
  end
endmodule

// File: rtl/rxp_admit.sv
module rxp_admit #(
  parameter int ROOM_W = 6
) (
  input  logic              chr_valid,
  input  logic              idle,
  input  logic              wide,
  input  logic [ROOM_W-1:0] room,
  output logic              accept,
  output logic              drop
);
  logic [ROOM_W-1:0] need;

  always_comb begin
    need   = wide ? ROOM_W'(2) : ROOM_W'(1);
    accept = chr_valid && idle && (room >= need);
    drop   = chr_valid && !accept;
  end
endmodule

// File: rtl/rxp_sequencer.sv
module rxp_sequencer
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  pk_pair_t          pair_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output pk_state_e         state
);
  pk_pair_t hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PK_IDLE;
    end else begin
      case (state)
        PK_IDLE: if (load) state <= PK_DATA;
        PK_DATA: if (out_ready) state <= hold.wide ? PK_STAT : PK_IDLE;
        PK_STAT: if (out_ready) state <= PK_IDLE;
        default: state <= PK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == PK_IDLE && load) hold <= pair_in;
  end

  always_comb begin
    out_valid = (state != PK_IDLE);
    out_data  = (state == PK_STAT) ? hold.stat : hold.data;
  end
endmodule

// File: rtl/rx_status_packer.sv
module rx_status_packer
  import rxp_pkg::*;
#(
  parameter int ROOM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_wide,
  input  logic              chr_valid,
  input  logic [8:0]        chr_data,
  input  logic              chr_parity_err,
  input  logic              chr_frame_err,
  input  logic              chr_break,
  input  logic              chr_overrun,
  input  logic              out_ready,
  input  logic [ROOM_W-1:0] fifo_room,
  output logic              out_valid,
  output logic [7:0]        out_data
);
  pk_state_e seq_state;
  pk_pair_t  fmt_pair;
  logic      accept;
  logic      drop;
  logic      sticky_ovr;

  rxp_format u_fmt (
    .char_in (chr_data),
    .bits    (cfg_bits),
    .par_en  (cfg_parity_en),
    .wide    (cfg_wide),
    .pe      (chr_parity_err),
    .fe      (chr_frame_err),
    .brk     (chr_break),
    .ovr     (chr_overrun | sticky_ovr),
    .pair    (fmt_pair)
  );

  rxp_admit #(.ROOM_W(ROOM_W)) u_adm (
    .chr_valid (chr_valid),
    .idle      (seq_state == PK_IDLE),
    .wide      (cfg_wide),
    .room      (fifo_room),
    .accept    (accept),
    .drop      (drop)
  );

  rxp_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .pair_in   (fmt_pair),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state     (seq_state)
  );

  always_ff @(posedge clk) begin
    if (rst)         sticky_ovr <= 1'b0;
    else if (accept) sticky_ovr <= 1'b0;
    else if (drop)   sticky_ovr <= 1'b1;
  end
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker
  import rxp_pkg::*;
#(
  parameter int ROOM_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              chr_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [ROOM_W-1:0] fifo_room,
  input logic              accept,
  input logic              sticky_ovr,
  input pk_state_e         seq_state
);
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stat_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    seq_state == PK_STAT |-> out_data[7:4] == 4'b0);

  p_stat_follows_data_r4: assert property (@(posedge clk) disable iff (rst)
    seq_state == PK_STAT |-> $past(seq_state) == PK_DATA || $past(seq_state) == PK_STAT);

  p_stat_then_idle_r4: assert property (@(posedge clk) disable iff (rst)
    seq_state == PK_STAT && out_ready |=> seq_state == PK_IDLE);

  p_drop_sets_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    chr_valid && !accept |=> sticky_ovr);

  p_accept_needs_room_r8: assert property (@(posedge clk) disable iff (rst)
    accept |-> seq_state == PK_IDLE && fifo_room != '0);

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> !out_valid && !sticky_ovr);
endmodule

bind rx_status_packer rxp_checker #(.ROOM_W(ROOM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chr_valid  (chr_valid),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .fifo_room  (fifo_room),
  .accept     (accept),
  .sticky_ovr (sticky_ovr),
  .seq_state  (seq_state)
);

// File: tb/rx_status_packer_test.sv
module rx_status_packer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_bits = 3'd3;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_wide = 1'b0;
  logic       chr_valid = 1'b0;
  logic [8:0] chr_data = '0;
  logic       chr_parity_err = 1'b0;
  logic       chr_frame_err = 1'b0;
  logic       chr_break = 1'b0;
  logic       chr_overrun = 1'b0;
  logic       out_ready;
  logic [5:0] fifo_room;
  logic       out_valid;
  logic [7:0] out_data;
  logic       stall = 1'b0;

  int errors = 0;
  int checks = 0;
  int wr_total = 0;
  int wr_mark = 0;
  int room_lim = 32;
  logic [7:0] wlog [0:255];
  bit done = 0;

  always #2 clk = ~clk;

  rx_status_packer uut (
    .clk(clk), .rst(rst), .cfg_bits(cfg_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_wide(cfg_wide), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_parity_err(chr_parity_err), .chr_frame_err(chr_frame_err),
    .chr_break(chr_break), .chr_overrun(chr_overrun), .out_ready(out_ready),
    .fifo_room(fifo_room), .out_valid(out_valid), .out_data(out_data)
  );

  always_comb begin
    int left;
    left = room_lim - (wr_total - wr_mark);
    if (left < 0) left = 0;
    if (left > 63) left = 63;
    fifo_room = 6'(left);
    out_ready = !stall && (fifo_room != 6'd0);
  end

  always @(posedge clk) begin
    if (!rst && out_valid && out_ready) begin
      wlog[wr_total[7:0]] <= out_data;
      wr_total <= wr_total + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_room(input int n);
    wr_mark = wr_total;
    room_lim = n;
  endtask

  task automatic send(input logic [8:0] d, input logic [2:0] b, input logic w,
                      input logic pen, input logic pe, input logic fe,
                      input logic bk, input logic ov);
    @(negedge clk);
    chr_data = d; cfg_bits = b; cfg_wide = w; cfg_parity_en = pen;
    chr_parity_err = pe; chr_frame_err = fe; chr_break = bk; chr_overrun = ov;
    chr_valid = 1'b1;
    @(negedge clk);
    chr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_one(input string req, input int start, input int b0);
    check({req, " count"}, wr_total - start, 1);
    check({req, " byte"}, wlog[start[7:0]], b0);
  endtask

  task automatic expect_two(input string req, input int start, input int b0, input int b1);
    check({req, " count"}, wr_total - start, 2);
    check({req, " data"}, wlog[start[7:0]], b0);
    check({req, " status"}, wlog[8'(start + 1)], b1);
  endtask

  task automatic t_reset();
    check("R11 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_normal();
    int s;
    set_room(32);
    s = wr_total; send(9'h0A5, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); settle();
    expect_one("R1 plain with errors", s, 8'hA5);
    s = wr_total; send(9'h1FF, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_one("R2 5-bit", s, 8'h1F);
    s = wr_total; send(9'h1FF, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_one("R2 6-bit", s, 8'h3F);
    s = wr_total; send(9'h1FF, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_one("R2 7-bit", s, 8'h7F);
    s = wr_total; send(9'h1C3, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); settle();
    expect_one("R3 9-bit plain", s, 8'hC3);
  endtask

  task automatic t_wide();
    int s;
    set_room(32);
    s = wr_total; send(9'h05A, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); settle();
    expect_two("R4 R5 pe fe", s, 8'h5A, 8'h05);
    s = wr_total; send(9'h033, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    expect_two("R5 brk ovr", s, 8'h33, 8'h0A);
    s = wr_total; send(9'h0FF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); settle();
    expect_two("R6 parity disabled", s, 8'h3F, 8'h00);
    s = wr_total; send(9'h1F0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); settle();
    expect_two("R7 ninth bit set", s, 8'hF0, 8'h05);
    s = wr_total; send(9'h00F, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); settle();
    expect_two("R7 ninth bit clear", s, 8'h0F, 8'h00);
  endtask

  task automatic t_room();
    int s;
    set_room(1);
    s = wr_total; send(9'h011, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    check("R8 no room drop count", wr_total - s, 0);
    set_room(32);
    s = wr_total; send(9'h022, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_two("R9 sticky reported", s, 8'h22, 8'h08);
    s = wr_total; send(9'h044, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_two("R9 sticky cleared", s, 8'h44, 8'h00);
  endtask

  task automatic t_stall();
    int s;
    set_room(32);
    stall = 1'b1;
    s = wr_total;
    send(9'h0C6, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cfg_wide = 1'b0; cfg_bits = 3'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12 valid held", out_valid, 1);
      check("R12 data held", out_data, 8'hC6);
    end
    send(9'h099, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    stall = 1'b0;
    settle();
    expect_two("R10 R8 pair kept busy drop", s, 8'hC6, 8'h04);
    s = wr_total; send(9'h077, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    expect_two("R9 busy drop reported", s, 8'h77, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_wide();
    t_room();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule